// File: doc/BRIEF.md
# Tagged Register-Write Command Queue

This block sits between a host bus slave port and a register file. The host writes into a 4 KB window. Each word-aligned write in that window becomes one queue entry. The entry holds a register tag and the 32-bit data word. The tag is the byte offset within the window divided by 8, so writes that walk an incrementing address range land in consecutive tags. A consumer port on the far side pops the entries in arrival order.

A small control region next to the window lets software do three things:
- read how many entries are free;
- choose what happens to a write that meets a full queue: the write is either acknowledged and thrown away, or answered with a retry strobe that makes the bus master present it again;
- see whether the engine behind the consumer port is busy.

The control region occupies host addresses with bits [13:12] = 0. The window occupies addresses with bits [13:12] = 1.

Top module: `regwr_fifo`

## Requirements
- R1: After reset the queue is empty. `cmd_valid` is 0, the free-space register (control offset 0x000) reads DEPTH (256), and the retry-enable bit reads 0.
- R2: A host write to the window with address bits [1:0] = 0 is acknowledged and pushes one entry. The entry's tag is address bits [11:3] and its data is the write data. Entries leave through `cmd_tag`/`cmd_data` in the order they were pushed.
- R3: The free-space count drops by one on each push and rises by one on each pop. It is unchanged when a push and a pop share a cycle. It stays between 0 and DEPTH, and a pop request on an empty queue has no effect.
- R4: With retry disabled, a window write to a full queue is acknowledged with `host_wr_retry` low and creates no entry.
- R5: Bit 0 of the control register at offset 0x008 enables retry mode, and the register reads back. In retry mode, a window write to a full queue gets `host_wr_retry` high and `host_wr_ack` low in the same cycle, and creates no entry. Once an entry has been popped, the same write is acknowledged and pushed.
- R6: Reads in the window return 0. The status register at offset 0x010 returns `engine_busy` in bit 0. `host_rd_data` is valid in the same cycle as `host_rd_valid`.
- R7: A window write with address bits [1:0] nonzero is acknowledged and discarded.
- R8: `cmd_valid` is high exactly when the free-space count is below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_valid | input | 1 | Host write request, held until acknowledged |
| host_wr_addr | input | 14 | Host write byte address |
| host_wr_data | input | 32 | Host write data |
| host_wr_ack | output | 1 | Write accepted this cycle |
| host_wr_retry | output | 1 | Write refused this cycle; present it again |
| host_rd_valid | input | 1 | Host read request |
| host_rd_addr | input | 14 | Host read byte address |
| host_rd_data | output | 32 | Read data, valid in the same cycle as the request |
| engine_busy | input | 1 | Busy indication from the consumer side |
| cmd_valid | output | 1 | Queue head available |
| cmd_tag | output | 9 | Register tag of the queue head |
| cmd_data | output | 32 | Data word of the queue head |
| cmd_ready | input | 1 | Consumer takes the head entry |

## Verification
The assertions check four properties on every cycle:
- the free-space count never exceeds DEPTH and moves by exactly one for a lone push or pop;
- retry and acknowledge never coincide, and retry appears only when the queue is full;
- `cmd_valid` tracks the count;
- a refused write leaves the count untouched.

Three behaviours show only in the bench's scenarios:
- entries are kept in order, with the right tags;
- a dropped write is really absent after a full drain;
- a retried write ends up as the last entry once space opens.

// File: rtl/regwr_fifo.sv
module regwr_fifo #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_valid,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  output logic              host_wr_ack,
  output logic              host_wr_retry,
  input  logic              host_rd_valid,
  input  logic [ADDR_W-1:0] host_rd_addr,
  output logic [DATA_W-1:0] host_rd_data,
  input  logic              engine_busy,
  output logic              cmd_valid,
  output logic [8:0]        cmd_tag,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_ready
);
  localparam int WIN_LSB = 12;
  localparam int TAG_W   = WIN_LSB - 3;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CNT_W   = PTR_W + 1;
  localparam int ENT_W   = TAG_W + DATA_W;
  localparam int HI_W    = ADDR_W - WIN_LSB;
  localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(DEPTH);
  localparam logic [WIN_LSB-1:0] OFS_FREE = 12'h000;
  localparam logic [WIN_LSB-1:0] OFS_CTRL = 12'h008;
  localparam logic [WIN_LSB-1:0] OFS_STAT = 12'h010;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] free_cnt;
  logic             retry_en;

  wire wr_in_regs = host_wr_addr[ADDR_W-1:WIN_LSB] == HI_W'(0);
  wire wr_in_win  = host_wr_addr[ADDR_W-1:WIN_LSB] == HI_W'(1);
  wire rd_in_regs = host_rd_addr[ADDR_W-1:WIN_LSB] == HI_W'(0);
  wire q_full     = free_cnt == '0;
  wire wr_aligned = host_wr_addr[1:0] == 2'b00;
  wire stall      = host_wr_valid && wr_in_win && q_full && retry_en;
  wire push       = host_wr_valid && wr_in_win && wr_aligned && !q_full;
  wire pop        = cmd_valid && cmd_ready;
  wire ctrl_wr    = host_wr_valid && wr_in_regs &&
                    host_wr_addr[WIN_LSB-1:0] == OFS_CTRL;

  assign host_wr_retry = stall;
  assign host_wr_ack   = host_wr_valid && !stall;
  assign cmd_valid     = free_cnt != FULL_FREE;
  assign {cmd_tag, cmd_data} = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {host_wr_addr[WIN_LSB-1:3], host_wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      free_cnt <= FULL_FREE;
      retry_en <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push && !pop)      free_cnt <= free_cnt - 1'b1;
      else if (pop && !push) free_cnt <= free_cnt + 1'b1;
      if (ctrl_wr) retry_en <= host_wr_data[0];
    end
  end

  always_comb begin
    host_rd_data = '0;
    if (host_rd_valid && rd_in_regs) begin
      case (host_rd_addr[WIN_LSB-1:0])
        OFS_FREE: host_rd_data = DATA_W'(free_cnt);
        OFS_CTRL: host_rd_data = DATA_W'(retry_en);
        OFS_STAT: host_rd_data = DATA_W'(engine_busy);
        default:  host_rd_data = '0;
      endcase
    end
  end

  // R3
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= FULL_FREE);

  // R3
  free_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> free_cnt == $past(free_cnt) - 1'b1);

  // R3
  free_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> free_cnt == $past(free_cnt) + 1'b1);

  // R5
  ack_retry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_ack && host_wr_retry));

  // R5
  retry_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_retry |-> (free_cnt == '0 && retry_en));

  // R4
  full_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_valid && wr_in_win && free_cnt == '0 && !cmd_ready) |=>
      free_cnt == '0);

  // R8
  valid_tracks_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid == (free_cnt < FULL_FREE));
endmodule

// File: tb/regwr_fifo_bench.sv
module regwr_fifo_bench;
  localparam int CYC = 20;
  localparam int NV  = 8;
  localparam logic [45:0] VEC [NV] = '{
    {14'h1000, 32'h1111_0000}, {14'h1008, 32'h2222_0001},
    {14'h1FF8, 32'h3333_0002}, {14'h1004, 32'h4444_0003},
    {14'h1800, 32'h5555_0004}, {14'h1010, 32'h6666_0005},
    {14'h1FFC, 32'h7777_0006}, {14'h1100, 32'h8888_0007}
  };

  logic clk = 0, rst_n = 0;
  logic host_wr_valid = 0, host_rd_valid = 0, engine_busy = 0, cmd_ready = 0;
  logic [13:0] host_wr_addr = '0, host_rd_addr = '0;
  logic [31:0] host_wr_data = '0;
  logic host_wr_ack, host_wr_retry, cmd_valid;
  logic [31:0] host_rd_data, cmd_data;
  logic [8:0] cmd_tag;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  regwr_fifo u_regwr_fifo (
    .clk(clk), .rst_n(rst_n),
    .host_wr_valid(host_wr_valid), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .host_wr_ack(host_wr_ack),
    .host_wr_retry(host_wr_retry), .host_rd_valid(host_rd_valid),
    .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
    .engine_busy(engine_busy), .cmd_valid(cmd_valid), .cmd_tag(cmd_tag),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d,
                    output logic ack, output logic rty);
    @(negedge clk);
    host_wr_valid = 1; host_wr_addr = a; host_wr_data = d;
    #1 ack = host_wr_ack; rty = host_wr_retry;
    @(posedge clk); #1 host_wr_valid = 0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd_valid = 1; host_rd_addr = a;
    #1 d = host_rd_data;
    host_rd_valid = 0;
  endtask

  task automatic pop(output logic v, output logic [8:0] t, output logic [31:0] d);
    @(negedge clk);
    v = cmd_valid; t = cmd_tag; d = cmd_data;
    cmd_ready = 1;
    @(posedge clk); #1 cmd_ready = 0;
  endtask

  initial begin
    #(CYC*150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack, rty, v;
    logic [8:0] t;
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(14'h0000, d); chk("R1 free", d, 32'd256);
    rd(14'h0008, d); chk("R1 ctrl", d, 32'd0);
    chk("R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);

    // R2 vector table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][45:32], VEC[i][31:0], ack, rty);
      chk("R2 ack", {30'd0, ack, rty}, 32'd2);
    end
    rd(14'h0000, d); chk("R3 free after pushes", d, 32'd248);
    for (int i = 0; i < NV; i++) begin
      pop(v, t, d);
      chk("R2 valid", {31'd0, v}, 32'd1);
      chk("R2 tag", {23'd0, t}, {23'd0, VEC[i][43:35]});
      chk("R2 data", d, VEC[i][31:0]);
    end
    rd(14'h0000, d); chk("R3 free after pops", d, 32'd256);
    chk("R8 empty", {31'd0, cmd_valid}, 32'd0);

    // R3 pop on empty has no effect
    pop(v, t, d);
    rd(14'h0000, d); chk("R3 empty pop", d, 32'd256);

    // R3 push and pop in one cycle
    wr(14'h1020, 32'hA5A5_0000, ack, rty);
    @(negedge clk);
    host_wr_valid = 1; host_wr_addr = 14'h1028; host_wr_data = 32'hA5A5_0001;
    cmd_ready = 1;
    @(posedge clk); #1 host_wr_valid = 0; cmd_ready = 0;
    rd(14'h0000, d); chk("R3 simultaneous", d, 32'd255);
    pop(v, t, d); chk("R3 second entry", d, 32'hA5A5_0001);
    chk("R3 second tag", {23'd0, t}, 32'd5);

    // R7 misaligned write dropped
    wr(14'h1002, 32'hBAD0_BAD0, ack, rty);
    chk("R7 ack", {31'd0, ack}, 32'd1);
    rd(14'h0000, d); chk("R7 free", d, 32'd256);

    // R6 reads
    rd(14'h1000, d); chk("R6 window read", d, 32'd0);
    engine_busy = 1;
    rd(14'h0010, d); chk("R6 busy high", d, 32'd1);
    engine_busy = 0;
    rd(14'h0010, d); chk("R6 busy low", d, 32'd0);

    // R4 drop mode on full
    for (int i = 0; i < 256; i++) wr(14'h1000 + 14'((i * 8) % 4096), 32'(i), ack, rty);
    rd(14'h0000, d); chk("R3 full", d, 32'd0);
    chk("R8 full valid", {31'd0, cmd_valid}, 32'd1);
    wr(14'h1040, 32'hDEAD_BEEF, ack, rty);
    chk("R4 ack no retry", {30'd0, ack, rty}, 32'd2);
    rd(14'h0000, d); chk("R4 free stays", d, 32'd0);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) begin
        pop(v, t, d);
        if (d !== 32'(i)) bad++;
      end
      chk("R4 order kept", 32'(bad), 32'd0);
    end
    chk("R4 dropped absent", {31'd0, cmd_valid}, 32'd0);

    // R5 retry mode
    wr(14'h0008, 32'h1, ack, rty);
    rd(14'h0008, d); chk("R5 ctrl readback", d, 32'd1);
    for (int i = 0; i < 256; i++) wr(14'h1000 + 14'((i * 8) % 4096), 32'(i), ack, rty);
    @(negedge clk);
    host_wr_valid = 1; host_wr_addr = 14'h1048; host_wr_data = 32'hC0DE_0001;
    #1 chk("R5 retry when full", {30'd0, host_wr_ack, host_wr_retry}, 32'd1);
    cmd_ready = 1;
    @(posedge clk); #1 cmd_ready = 0;
    chk("R5 ack after space", {30'd0, host_wr_ack, host_wr_retry}, 32'd2);
    @(posedge clk); #1 host_wr_valid = 0;
    rd(14'h0000, d); chk("R5 free after retry", d, 32'd0);
    for (int i = 0; i < 255; i++) pop(v, t, d);
    pop(v, t, d);
    chk("R5 retried data last", d, 32'hC0DE_0001);
    chk("R5 retried tag", {23'd0, t}, 32'd9);
    chk("R8 drained", {31'd0, cmd_valid}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule